// File: doc/BRIEF.md
# Collision-Safe Shared Mailbox Register

This block is one mailbox word shared by two agents on a single clock. One agent deposits words through a write stream. The other agent marks the span of its read with a level signal and takes the word from the data output during that span. An interrupt-pending flag tells the reader that a fresh word is waiting.

The register has two stages. The front stage takes every write. The back stage drives the output. While a read is in progress the back stage is locked. A write that lands inside that span waits in the front stage and moves to the output once the read ends. A finished read normally lowers the pending flag. If a write overlapped the read, the flag stays raised so the reader knows another word is waiting.

The write stream never applies back-pressure. `wr_ready` is held high, so every cycle with `wr_valid` high is an accepted write. A writer may hold `wr_valid` high on consecutive cycles, and each such cycle is a separate write. The read side is a plain control level and has no handshake.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset, `rd_data` is 0 and `rd_pending` is 0.
- R2: `wr_ready` is 1 in every cycle after reset, and a cycle with `wr_valid` high is always an accepted write.
- R3: A write accepted while `rd_active` is low appears on `rd_data` in the next cycle, and `rd_pending` is 1 in the next cycle.
- R4: During any cycle in which `rd_active` is high, `rd_data` keeps its value across that cycle's clock edge.
- R5: A write accepted while `rd_active` is high leaves `rd_data` unchanged. The written word appears on `rd_data` in the cycle after the first cycle in which `rd_active` is low again.
- R6: When several writes are accepted during one read, only the last of them reaches `rd_data` after the read.
- R7: A read that ends with no write accepted during it clears `rd_pending` in the cycle after the first cycle in which `rd_active` is low.
- R8: A write accepted during a read sets `rd_pending`, and the end of that read leaves `rd_pending` at 1.
- R9: A write accepted in the first cycle in which `rd_active` is low takes priority over a word parked during the read. Its data is output and `rd_pending` is 1, and the parked word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready, always 1 |
| wr_data | input | DATA_W | Write stream data |
| rd_active | input | 1 | High for the whole span of a read access |
| rd_data | output | DATA_W | Output-stage word |
| rd_pending | output | 1 | Interrupt-pending flag |

## Verification
The checks assume that `rd_active` and `wr_valid` are driven to clean levels, are synchronous to `clk`, and are held low during reset. They also assume that the end of a read is marked by at least one cycle with `rd_active` low. The bench changes its inputs only on the falling edge and keeps both controls low throughout reset. Every read it issues ends with at least one idle or write-only cycle, so back-to-back reads always have a gap.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic wr_fire;  // accepted write this cycle
    logic rd_busy;  // read span in progress
    logic rd_done;  // first low cycle after a read
  } mbx_ev_t;
endpackage

// File: rtl/mbx_rd_track.sv
module mbx_rd_track
  import mbx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_fire,
  input  logic rd_active,
  output mbx_ev_t ev,
  output logic overlap
);
  logic rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      overlap <= 1'b0;
    end else begin
      rd_q <= rd_active;
      if (ev.rd_done)
        overlap <= 1'b0;
      else if (wr_fire && rd_active)
        overlap <= 1'b1;
    end
  end

  always_comb begin
    ev.wr_fire = wr_fire;
    ev.rd_busy = rd_active;
    ev.rd_done = rd_q && !rd_active;
  end
endmodule

// File: rtl/mbx_dbuf.sv
module mbx_dbuf
  import mbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mbx_ev_t           ev,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] front_q;
  logic [DATA_W-1:0] back_q;
  logic              parked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      front_q  <= '0;
      back_q   <= '0;
      parked_q <= 1'b0;
    end else if (ev.wr_fire && !ev.rd_busy) begin
      front_q  <= din;
      back_q   <= din;
      parked_q <= 1'b0;
    end else if (ev.wr_fire) begin
      front_q  <= din;
      parked_q <= 1'b1;
    end else if (ev.rd_done && parked_q) begin
      back_q   <= front_q;
      parked_q <= 1'b0;
    end
  end

  assign dout = back_q;
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  mbx_ev_t ev,
  input  logic    overlap,
  output logic    pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      pending <= 1'b0;
    else if (ev.wr_fire)
      pending <= 1'b1;
    else if (ev.rd_done)
      pending <= overlap;
  end
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_active,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_pending
);
  mbx_ev_t ev;
  logic    overlap;
  logic    wr_fire;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  mbx_rd_track u_track (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
    .rd_active(rd_active), .ev(ev), .overlap(overlap)
  );

  mbx_dbuf #(.DATA_W(DATA_W)) u_dbuf (
    .clk(clk), .rst_n(rst_n), .ev(ev), .din(wr_data), .dout(rd_data)
  );

  mbx_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .overlap(overlap), .pending(rd_pending)
  );
endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_active,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_pending
);
  logic              saw_wr;
  logic [DATA_W-1:0] last_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saw_wr  <= 1'b0;
      last_wr <= '0;
    end else if (wr_valid && rd_active) begin
      saw_wr  <= 1'b1;
      last_wr <= wr_data;
    end else if (!rd_active) begin
      saw_wr  <= 1'b0;
    end
  end

  a_r4_hold_during_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |=> $stable(rd_data));

  a_r3_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !rd_active) |=> (rd_data == $past(wr_data)) && rd_pending);

  a_r8_write_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> rd_pending);

  a_r7_clear_on_read_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_active) && !wr_valid && !saw_wr) |=> !rd_pending);

  a_r8_keep_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_active) && saw_wr) |=> rd_pending);

  a_r6_last_parked_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_active) && !wr_valid && saw_wr) |=> (rd_data == $past(last_wr)));
endmodule

bind mbx_mailbox mbx_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .rd_active(rd_active), .rd_data(rd_data),
  .rd_pending(rd_pending)
);

// File: tb/tb_mbx_mailbox.sv
`timescale 1ns/1ps
module tb_mbx_mailbox;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [W-1:0] wr_data = '0;
  logic         rd_active = 1'b0;
  logic [W-1:0] rd_data;
  logic         rd_pending;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] data;
    logic         pend;
    string        req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  mbx_mailbox #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_active(rd_active), .rd_data(rd_data),
    .rd_pending(rd_pending)
  );

  // Monitor: compare registered outputs against queued expectations
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rd_data !== e.data || rd_pending !== e.pend) begin
        errors++;
        $display("FAIL %s: data=%0h pend=%0b expected data=%0h pend=%0b",
                 e.req, rd_data, rd_pending, e.data, e.pend);
      end
      checks++;
      if (wr_ready !== 1'b1) begin
        errors++;
        $display("FAIL R2: wr_ready=%0b expected 1", wr_ready);
      end
    end
  end

  task automatic step(input logic wv, input logic [W-1:0] wd, input logic ra,
                      input logic [W-1:0] xd, input logic xp, input string req);
    @(negedge clk);
    wr_valid  = wv;
    wr_data   = wd;
    rd_active = ra;
    @(posedge clk);
    #1;
    sb.push_back('{data: xd, pend: xp, req: req});
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R1");
    // R3 direct write
    step(1'b1, 8'hA5, 1'b0, 8'hA5, 1'b1, "R3");
    // R4 read span, two writes parked (R5, R6)
    step(1'b0, 8'h00, 1'b1, 8'hA5, 1'b1, "R4");
    step(1'b1, 8'h11, 1'b1, 8'hA5, 1'b1, "R5");
    step(1'b1, 8'h22, 1'b1, 8'hA5, 1'b1, "R6");
    // read ends: last parked word out, pending kept (R8)
    step(1'b0, 8'h00, 1'b0, 8'h22, 1'b1, "R6");
    step(1'b0, 8'h00, 1'b0, 8'h22, 1'b1, "R8");
    // clean read clears pending (R7)
    for (int i = 0; i < 4; i++)
      step(1'b0, 8'h00, 1'b1, 8'h22, 1'b1, "R4");
    step(1'b0, 8'h00, 1'b0, 8'h22, 1'b0, "R7");
    // read with no pending and no write: nothing changes
    step(1'b0, 8'h00, 1'b1, 8'h22, 1'b0, "R4");
    step(1'b0, 8'h00, 1'b0, 8'h22, 1'b0, "R7");
    // parked word overridden by write in first low cycle (R9)
    step(1'b0, 8'h00, 1'b1, 8'h22, 1'b0, "R4");
    step(1'b1, 8'h33, 1'b1, 8'h22, 1'b1, "R8");
    step(1'b1, 8'h44, 1'b0, 8'h44, 1'b1, "R9");
    step(1'b0, 8'h00, 1'b0, 8'h44, 1'b1, "R9");
    step(1'b0, 8'h00, 1'b1, 8'h44, 1'b1, "R4");
    step(1'b0, 8'h00, 1'b0, 8'h44, 1'b0, "R7");
    // back-to-back direct writes, then single parked write (R5)
    step(1'b1, 8'h5A, 1'b0, 8'h5A, 1'b1, "R3");
    step(1'b1, 8'hC3, 1'b0, 8'hC3, 1'b1, "R3");
    step(1'b1, 8'h7E, 1'b1, 8'hC3, 1'b1, "R5");
    step(1'b0, 8'h00, 1'b1, 8'hC3, 1'b1, "R4");
    step(1'b0, 8'h00, 1'b0, 8'h7E, 1'b1, "R5");
    step(1'b0, 8'h00, 1'b1, 8'h7E, 1'b1, "R4");
    step(1'b0, 8'h00, 1'b0, 8'h7E, 1'b0, "R7");
    // reset again returns to R1 state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule